// File: doc/BRIEF.md
# Synthesizer Tuning Register Write Port

This block is the processor-side parallel port of a direct digital synthesizer. A host puts a 16-bit word and a 3-bit register address on its buses and pulses an active-low write strobe. The block latches both buses on the strobe's rising edge. On the next rising edge of the master clock it copies the latched word into the addressed tuning register. The register bank holds two 32-bit frequency tuning words, each loaded as two 16-bit halves, and four 12-bit phase offset words. All six registers drive the synthesis core continuously.

The strobe is treated as its own clock. The host must let the strobe rise some nanoseconds before a master clock edge. Each strobe commits exactly once, and strobes may arrive as often as once per master clock cycle. Reset only puts the transfer logic in a known state. It does not touch the tuning registers, which start undefined, so software must load them after power-up.

Top module: `ddsw_tuning_port`

## Requirements
- R1: Data and address are sampled only at the rising edge of `wrN`. Changes on `dataIn` or `addrIn` while `wrN` stays high, or before it rises, do not reach any register.
- R2: The addressed register takes the latched word at the first rising edge of `clk` after `wrN` rises, and not earlier.
- R3: Address decoding: 0 and 1 load bits 15:0 and 31:16 of frequency word 0. 2 and 3 load the same halves of frequency word 1. 4 to 7 load phase words 0 to 3.
- R4: A phase write stores `dataIn[11:0]`. Bits 15:12 are ignored.
- R5: Each strobe changes exactly one register field. All other fields keep their values, and nothing changes on cycles with no pending strobe.
- R6: Strobes in consecutive master clock cycles each commit, in order. When two such strobes target the same field, the later one is left in it.
- R7: Reset leaves the tuning registers unchanged. A strobe that rises while reset is asserted commits nothing.
- R8: Holding `wrN` low for many cycles commits nothing while it is low, and exactly one write when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; commits happen on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of the transfer logic only |
| wrN | input | 1 | Active-low write strobe; the rising edge latches the buses |
| dataIn | input | 16 | Write data |
| addrIn | input | 3 | Destination register address |
| freqWords | output | 64 | Frequency word 1 in bits 63:32, frequency word 0 in bits 31:0 |
| phaseWords | output | 48 | Phase word n in bits 12n+11:12n |

## Verification
Any fault in the capture, transfer or decode logic shows up at the register outputs within one master clock cycle of a strobe. The possible faults are: a wrong field receives the word, a neighbouring field is disturbed, the top data bits leak into a phase word, or a write lands one edge early or late. The bench therefore compares every output field against an arithmetic model twice per write, once just before the commit edge and once just after it. A lost or duplicated toggle event shows up as a missing or spurious change, either within back-to-back bursts or after long strobe pulses. Retention across reset is observed directly on the outputs.

// File: rtl/ddsw_pkg.sv
`timescale 1ns/1ps
package ddsw_pkg;
  parameter int DATA_W    = 16;
  parameter int ADDR_W    = 3;
  parameter int NUM_FREQ  = 2;
  parameter int NUM_PHASE = 4;
  parameter int PHASE_W   = 12;

  localparam int FREQ_W     = 2 * DATA_W;
  localparam int PHASE_BASE = 2 * NUM_FREQ;

  // strobes from control to datapath, one per register field
  typedef struct packed {
    logic [DATA_W-1:0]    data;
    logic [NUM_FREQ-1:0]  freqLoWe;
    logic [NUM_FREQ-1:0]  freqHiWe;
    logic [NUM_PHASE-1:0] phaseWe;
  } wrStrb_t;
endpackage

// File: rtl/ddsw_capture.sv
`timescale 1ns/1ps
// Strobe-domain latch: buses are taken on the rising edge of wrN and a
// flag toggles once per strobe to announce the new word.
module ddsw_capture
  import ddsw_pkg::*;
(
  input  logic              rstN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] capData,
  output logic [ADDR_W-1:0] capAddr,
  output logic              capTgl
);
  always_ff @(posedge wrN) begin
    capData <= dataIn;
    capAddr <= addrIn;
  end

  // held at zero in reset so strobes during reset announce nothing
  always_ff @(posedge wrN or negedge rstN) begin
    if (!rstN) capTgl <= 1'b0;
    else       capTgl <= ~capTgl;
  end
endmodule

// File: rtl/ddsw_ctrl.sv
`timescale 1ns/1ps
// Master-clock side: optional staging of the announced word, event
// detection on the toggle flag, and address decode into write strobes.
module ddsw_ctrl
  import ddsw_pkg::*;
#(
  parameter int SYNC_STAGES = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capTgl,
  input  logic [DATA_W-1:0] capData,
  input  logic [ADDR_W-1:0] capAddr,
  output wrStrb_t           strb
);
  logic              stTgl;
  logic [DATA_W-1:0] stData;
  logic [ADDR_W-1:0] stAddr;
  logic              seenTgl;
  logic              commitNow;

  if (SYNC_STAGES == 0) begin : gDirect
    // timing-compliant strobe: commit on the very next clock edge
    assign stTgl  = capTgl;
    assign stData = capData;
    assign stAddr = capAddr;
  end else begin : gStaged
    // word and flag travel together so back-to-back strobes stay paired
    logic [SYNC_STAGES-1:0] tglPipe;
    logic [DATA_W-1:0]      dataPipe [SYNC_STAGES];
    logic [ADDR_W-1:0]      addrPipe [SYNC_STAGES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tglPipe <= '0;
      end else begin
        tglPipe[0] <= capTgl;
        for (int i = 1; i < SYNC_STAGES; i++) tglPipe[i] <= tglPipe[i-1];
      end
    end

    always_ff @(posedge clk) begin
      dataPipe[0] <= capData;
      addrPipe[0] <= capAddr;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        dataPipe[i] <= dataPipe[i-1];
        addrPipe[i] <= addrPipe[i-1];
      end
    end

    assign stTgl  = tglPipe[SYNC_STAGES-1];
    assign stData = dataPipe[SYNC_STAGES-1];
    assign stAddr = addrPipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenTgl <= 1'b0;
    else       seenTgl <= stTgl;
  end

  assign commitNow = stTgl ^ seenTgl;

  always_comb begin
    strb      = '0;
    strb.data = stData;
    for (int f = 0; f < NUM_FREQ; f++) begin
      strb.freqLoWe[f] = commitNow && (stAddr == ADDR_W'(2 * f));
      strb.freqHiWe[f] = commitNow && (stAddr == ADDR_W'(2 * f + 1));
    end
    for (int p = 0; p < NUM_PHASE; p++) begin
      strb.phaseWe[p] = commitNow && (stAddr == ADDR_W'(PHASE_BASE + p));
    end
  end
endmodule

// File: rtl/ddsw_datapath.sv
`timescale 1ns/1ps
// Tuning register bank. No reset: contents are undefined until loaded.
module ddsw_datapath
  import ddsw_pkg::*;
(
  input  logic                          clk,
  input  wrStrb_t                       strb,
  output logic [NUM_FREQ*FREQ_W-1:0]    freqWords,
  output logic [NUM_PHASE*PHASE_W-1:0]  phaseWords
);
  for (genvar f = 0; f < NUM_FREQ; f++) begin : gFreq
    logic [FREQ_W-1:0] freqReg;
    always_ff @(posedge clk) begin
      if (strb.freqLoWe[f]) freqReg[DATA_W-1:0]      <= strb.data;
      if (strb.freqHiWe[f]) freqReg[FREQ_W-1:DATA_W] <= strb.data;
    end
    assign freqWords[f*FREQ_W +: FREQ_W] = freqReg;
  end

  for (genvar p = 0; p < NUM_PHASE; p++) begin : gPhase
    logic [PHASE_W-1:0] phaseReg;
    always_ff @(posedge clk) begin
      if (strb.phaseWe[p]) phaseReg <= strb.data[PHASE_W-1:0];
    end
    assign phaseWords[p*PHASE_W +: PHASE_W] = phaseReg;
  end
endmodule

// File: rtl/ddsw_tuning_port.sv
`timescale 1ns/1ps
module ddsw_tuning_port
  import ddsw_pkg::*;
#(
  parameter int SYNC_STAGES = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrN,
  input  logic [DATA_W-1:0]            dataIn,
  input  logic [ADDR_W-1:0]            addrIn,
  output logic [NUM_FREQ*FREQ_W-1:0]   freqWords,
  output logic [NUM_PHASE*PHASE_W-1:0] phaseWords
);
  logic [DATA_W-1:0] capData;
  logic [ADDR_W-1:0] capAddr;
  logic              capTgl;
  wrStrb_t           ctrlStrb;

  ddsw_capture u_capture (
    .rstN    (rstN),
    .wrN     (wrN),
    .dataIn  (dataIn),
    .addrIn  (addrIn),
    .capData (capData),
    .capAddr (capAddr),
    .capTgl  (capTgl)
  );

  ddsw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .capTgl  (capTgl),
    .capData (capData),
    .capAddr (capAddr),
    .strb    (ctrlStrb)
  );

  ddsw_datapath u_datapath (
    .clk        (clk),
    .strb       (ctrlStrb),
    .freqWords  (freqWords),
    .phaseWords (phaseWords)
  );
endmodule

// File: rtl/ddsw_checker.sv
`timescale 1ns/1ps
module ddsw_checker
  import ddsw_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input wrStrb_t                      strb,
  input logic [NUM_FREQ*FREQ_W-1:0]   freqWords,
  input logic [NUM_PHASE*PHASE_W-1:0] phaseWords
);
  logic commitAny;
  assign commitAny = |{strb.freqLoWe, strb.freqHiWe, strb.phaseWe};

  always_comb begin
    assert_reset_quiet_R7: assert (rstN || !commitAny);
  end

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.freqLoWe, strb.freqHiWe, strb.phaseWe}));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !commitAny |=> ($stable(freqWords) && $stable(phaseWords)));

  assert_freq0_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.freqLoWe[0] |=> (freqWords[DATA_W-1:0] == $past(strb.data)));

  assert_freq_last_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.freqHiWe[NUM_FREQ-1] |=>
      (freqWords[NUM_FREQ*FREQ_W-1 -: DATA_W] == $past(strb.data)));

  assert_phase_low_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.phaseWe[NUM_PHASE-1] |=>
      (phaseWords[NUM_PHASE*PHASE_W-1 -: PHASE_W] == $past(strb.data[PHASE_W-1:0])));

  assert_phase_spares_freq_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.phaseWe[0] |=> $stable(freqWords));
endmodule

bind ddsw_tuning_port ddsw_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strb       (ctrlStrb),
  .freqWords  (freqWords),
  .phaseWords (phaseWords)
);

// File: tb/tb_ddsw_tuning_port.sv
`timescale 1ns/100ps
module tb_ddsw_tuning_port;
  import ddsw_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [2:0]  addrIn = '0;
  logic [63:0] freqWords;
  logic [47:0] phaseWords;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [31:0] expFreq [2];
  logic [11:0] expPhase [4];

  always #2.5 clk = ~clk;

  ddsw_tuning_port dut (
    .clk(clk), .rstN(rstN), .wrN(wrN), .dataIn(dataIn), .addrIn(addrIn),
    .freqWords(freqWords), .phaseWords(phaseWords)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int f = 0; f < 2; f++) chk(req, freqWords[f*32 +: 32], expFreq[f]);
    for (int p = 0; p < 4; p++) chk(req, {20'd0, phaseWords[p*12 +: 12]}, {20'd0, expPhase[p]});
  endtask

  // R3 map and R4 masking, computed independently
  task automatic applyModel(input int a, input logic [15:0] d);
    if (a < 4) begin
      if (a % 2 == 1) expFreq[a/2][31:16] = d;
      else            expFreq[a/2][15:0]  = d;
    end else begin
      expPhase[a-4] = d[11:0];
    end
  endtask

  // one strobe, checked just before and just after the commit edge
  task automatic writeReg(input int a, input logic [15:0] d, input string req);
    @(posedge clk); #1;
    addrIn = 3'(a); dataIn = d; wrN = 1'b0;
    #1 wrN = 1'b1;
    #0.5 checkAll("R2 before commit edge");
    applyModel(a, d);
    #1 dataIn = ~d; addrIn = 3'(a) ^ 3'd7;   // R1: bus changes after the strobe
    @(posedge clk); #1;
    checkAll(req);
  endtask

  task automatic burstStrobe(input int a, input logic [15:0] d);
    @(posedge clk); #1;
    addrIn = 3'(a); dataIn = d; wrN = 1'b0;
    #1 wrN = 1'b1;
    applyModel(a, d);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    for (int f = 0; f < 2; f++) expFreq[f] = 'x;
    for (int p = 0; p < 4; p++) expPhase[p] = 'x;

    // load zeros into every register so the model is fully defined (R3)
    for (int a = 0; a < 8; a++) begin
      @(posedge clk); #1;
      addrIn = 3'(a); dataIn = 16'h0000; wrN = 1'b0;
      #1 wrN = 1'b1;
      applyModel(a, 16'h0000);
    end
    @(posedge clk); #1 checkAll("R3 zero init");

    // sweep: every address, walking ones and walking zeros (R3, R4, R5)
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [15:0] d;
        d = 16'h0001 << b;
        if (b % 2 == 1) d = ~d;
        writeReg(a, d, (a < 4) ? "R3 sweep" : "R4 sweep");
      end
    end

    // R4: upper four bits ignored on a phase write
    writeReg(6, 16'hF123, "R4 masked upper bits");
    chk("R4 explicit", {20'd0, phaseWords[2*12 +: 12]}, 32'h123);
    writeReg(7, 16'h0ABC, "R4 clean");

    // R6: one strobe per clock into every register, then same field twice
    for (int a = 0; a < 8; a++) burstStrobe(a, 16'h1357 + 16'(a) * 16'h2111);
    @(posedge clk); #1 checkAll("R6 burst all fields");
    burstStrobe(2, 16'hAAAA);
    burstStrobe(2, 16'h5555);
    burstStrobe(5, 16'hFFFF);
    burstStrobe(3, 16'h9876);
    @(posedge clk); #1 checkAll("R6 same field twice");
    chk("R6 last wins", {16'd0, freqWords[47:32]}, 32'h5555);

    // R8: long low pulse, data settles late, commit only at rising edge
    @(posedge clk); #1;
    addrIn = 3'd1; dataIn = 16'h1111; wrN = 1'b0;
    repeat (6) @(posedge clk);
    #1 checkAll("R8 while held low");
    dataIn = 16'h2468;
    @(posedge clk); #1 wrN = 1'b1;
    applyModel(1, 16'h2468);
    @(posedge clk); #1 checkAll("R8 after rise");
    repeat (6) @(posedge clk);
    #1 checkAll("R8 no repeat");

    // R1: buses wander with the strobe idle
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      addrIn = 3'(i); dataIn = 16'(i) * 16'h3333;
    end
    @(posedge clk); #1 checkAll("R1 idle bus activity");

    // R7: strobe during reset, registers retained
    @(posedge clk); #1 rstN = 1'b0;
    #0.5 addrIn = 3'd0; dataIn = 16'hBEEF; wrN = 1'b0;
    #1 wrN = 1'b1;
    repeat (3) @(posedge clk);
    #1 checkAll("R7 during reset");
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1 checkAll("R7 after reset");
    writeReg(0, 16'hC0DE, "R7 write after reset");
    writeReg(4, 16'h7FED, "R7 write after reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule